// File: doc/BRIEF.md
# Vector Widening-Extend Legality Checker

This block sits in the decode path of a vector unit. It judges whether a zero-extend or sign-extend instruction may run under the current vector type. These instructions widen each source element by a factor of 2, 4 or 8. The block takes four inputs from the instruction and the vector type:

- the instruction's extension factor and its signedness;
- the current selected element width (SEW);
- the register-group multiplier (LMUL);
- the vector-type illegal flag.

From these it derives the width of the source elements and the source register-group multiplier. One cycle after the input strobe it reports, through registered outputs, whether the instruction is legal or must raise an illegal-instruction exception.

Only the derived source element width decides legality. The source multiplier is computed and reported for later stages. It is never used to reject the instruction, even when it falls below the smallest configurable LMUL.

Top module: `vext_legality`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are 0 after that edge.
- R2: `res_valid` equals `in_valid` delayed by exactly one clock cycle.
- R3: Factor encoding is `fx_sel` 2'b01 = x2, 2'b10 = x4, 2'b11 = x8, with log2 factor 1, 2, 3. `res_eew_log2` (unsigned) is log2 of the source element width in bits, that is `sew_sel` + 3 − log2 factor. SEW is 8 << `sew_sel`.
- R4: A source element width below 8 bits (`res_eew_log2` < 3) makes the instruction illegal. So with SEW 8 every factor is illegal, with SEW 16 only x2 is legal, and with SEW 32 x2 and x4 are legal while x8 is illegal.
- R5: `res_emul_log2` (4-bit signed) equals `lmul_sel` (3-bit signed log2 of LMUL) minus log2 factor. A result below −3 does not by itself make the instruction illegal.
- R6: When `vill` is 1 the instruction is illegal, whatever the other inputs are.
- R7: The reserved factor code 2'b00 is illegal. For it the log2 factor is taken as 0.
- R8: A `sew_sel` above log2(ELEN/8) (3 by default) is illegal. The reserved `lmul_sel` code 3'b100 is also illegal.
- R9: When `res_valid` is 1, exactly one of `res_legal` and `res_illegal` is 1. When `res_valid` is 0, both are 0.
- R10: `res_signed` carries the captured `sx_en`. Signedness has no effect on legality, on `res_eew_log2` or on `res_emul_log2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: inputs hold an instruction to judge |
| fx_sel | input | 2 | Extension factor code |
| sx_en | input | 1 | 1 = sign-extend, 0 = zero-extend |
| sew_sel | input | 3 | log2(SEW/8) |
| lmul_sel | input | 3 | Signed log2 of LMUL |
| vill | input | 1 | Current vector type is illegal |
| res_valid | output | 1 | Result valid |
| res_legal | output | 1 | Instruction may execute |
| res_illegal | output | 1 | Illegal-instruction exception |
| res_signed | output | 1 | Captured signedness |
| res_eew_log2 | output | 4 | log2 of source element width in bits |
| res_emul_log2 | output | 4 | Signed log2 of source EMUL |

## Verification
The sharpest case is SEW 64 with LMUL 1/8 and factor 8. It gives a legal 8-bit source with an EMUL of 1/64. A design that still rejected on EMUL would flag it illegal, and the legality bits would miscompare. The SEW 8/16/32 boundary rows catch an off-by-one in the width comparison, which would accept or reject the wrong factor. Further rows cover the following:

- a set `vill` flag on an otherwise legal instruction, which a design that skipped it would pass;
- a reserved factor code;
- a reserved LMUL code;
- an oversize SEW.

Directed tests probe the one-cycle latency with back-to-back strobes and gaps, a reset that arrives while an instruction is in flight, and the flip of signedness. A dropped register stage, or a leak of signedness into the result, would show as a miscompare.

// File: rtl/vext_pkg.sv
package vext_pkg;

  typedef enum logic [1:0] {
    FX_RSVD = 2'b00,
    FX_X2   = 2'b01,
    FX_X4   = 2'b10,
    FX_X8   = 2'b11
  } fx_code_e;

  // log2 of the widening factor; reserved code maps to 0
  function automatic logic [1:0] fx_log2(input logic [1:0] code);
    case (code)
      FX_X2:   fx_log2 = 2'd1;
      FX_X4:   fx_log2 = 2'd2;
      FX_X8:   fx_log2 = 2'd3;
      default: fx_log2 = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vext_factor_dec.sv
module vext_factor_dec
  import vext_pkg::*;
(
  input  logic [1:0] fx_sel,
  output logic [1:0] fx_lg,
  output logic       fx_ok
);

  always_comb begin
    fx_lg = fx_log2(fx_sel);
    fx_ok = (fx_sel != FX_RSVD);
  end

endmodule

// File: rtl/vext_width_calc.sv
module vext_width_calc #(
  parameter int ELEN     = 64,
  parameter int SEW_W    = 3,
  parameter int LMUL_W   = 3,
  parameter int EEW_W    = 4,
  parameter int EMUL_W   = 4,
  parameter int MIN_EEWL = 3
) (
  input  logic [SEW_W-1:0]         sew_sel,
  input  logic [LMUL_W-1:0]        lmul_sel,
  input  logic [1:0]               fx_lg,
  output logic [EEW_W-1:0]         eew_lg,
  output logic signed [EMUL_W-1:0] emul_lg,
  output logic                     eew_ok,
  output logic                     sew_ok,
  output logic                     lmul_ok
);

  localparam int                MAX_SEW_SEL = $clog2(ELEN) - MIN_EEWL;
  localparam logic [SEW_W-1:0]  SEW_LIMIT   = SEW_W'(MAX_SEW_SEL);
  localparam logic [EEW_W-1:0]  EEW_FLOOR   = EEW_W'(MIN_EEWL);
  localparam logic [LMUL_W-1:0] LMUL_RSVD   = {1'b1, {(LMUL_W-1){1'b0}}};

  logic [EEW_W-1:0]         sew_bits_lg;
  logic signed [EMUL_W-1:0] lmul_ext;
  logic signed [EMUL_W-1:0] fx_ext;

  always_comb begin
    sew_bits_lg = EEW_W'(sew_sel) + EEW_FLOOR;
    eew_lg      = sew_bits_lg - EEW_W'(fx_lg);
    lmul_ext    = {{(EMUL_W-LMUL_W){lmul_sel[LMUL_W-1]}}, lmul_sel};
    fx_ext      = {{(EMUL_W-2){1'b0}}, fx_lg};
    emul_lg     = lmul_ext - fx_ext;
    eew_ok      = (eew_lg >= EEW_FLOOR);
    sew_ok      = (sew_sel <= SEW_LIMIT);
    lmul_ok     = (lmul_sel != LMUL_RSVD);
  end

endmodule

// File: rtl/vext_result_reg.sv
module vext_result_reg #(
  parameter int EEW_W  = 4,
  parameter int EMUL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              ok_all,
  input  logic              sx_en,
  input  logic [EEW_W-1:0]  eew_lg,
  input  logic [EMUL_W-1:0] emul_lg,
  output logic              res_valid,
  output logic              res_legal,
  output logic              res_illegal,
  output logic              res_signed,
  output logic [EEW_W-1:0]  res_eew_log2,
  output logic [EMUL_W-1:0] res_emul_log2
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid     <= 1'b0;
      res_legal     <= 1'b0;
      res_illegal   <= 1'b0;
      res_signed    <= 1'b0;
      res_eew_log2  <= '0;
      res_emul_log2 <= '0;
    end else begin
      res_valid   <= in_valid;
      res_legal   <= in_valid & ok_all;
      res_illegal <= in_valid & ~ok_all;
      if (in_valid) begin
        res_signed    <= sx_en;
        res_eew_log2  <= eew_lg;
        res_emul_log2 <= emul_lg;
      end
    end
  end

endmodule

// File: rtl/vext_legality.sv
module vext_legality #(
  parameter int ELEN   = 64,
  parameter int SEW_W  = 3,
  parameter int LMUL_W = 3,
  parameter int EEW_W  = 4,
  parameter int EMUL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        fx_sel,
  input  logic              sx_en,
  input  logic [SEW_W-1:0]  sew_sel,
  input  logic [LMUL_W-1:0] lmul_sel,
  input  logic              vill,
  output logic              res_valid,
  output logic              res_legal,
  output logic              res_illegal,
  output logic              res_signed,
  output logic [EEW_W-1:0]  res_eew_log2,
  output logic [EMUL_W-1:0] res_emul_log2
);

  localparam int MIN_EEWL = 3;

  logic [1:0]               fx_lg;
  logic                     fx_ok;
  logic [EEW_W-1:0]         eew_lg;
  logic signed [EMUL_W-1:0] emul_lg;
  logic                     eew_ok, sew_ok, lmul_ok, ok_all;

  vext_factor_dec u_fdec (
    .fx_sel (fx_sel),
    .fx_lg  (fx_lg),
    .fx_ok  (fx_ok)
  );

  vext_width_calc #(
    .ELEN(ELEN), .SEW_W(SEW_W), .LMUL_W(LMUL_W),
    .EEW_W(EEW_W), .EMUL_W(EMUL_W), .MIN_EEWL(MIN_EEWL)
  ) u_calc (
    .sew_sel  (sew_sel),
    .lmul_sel (lmul_sel),
    .fx_lg    (fx_lg),
    .eew_lg   (eew_lg),
    .emul_lg  (emul_lg),
    .eew_ok   (eew_ok),
    .sew_ok   (sew_ok),
    .lmul_ok  (lmul_ok)
  );

  // EMUL deliberately plays no part in this verdict
  assign ok_all = ~vill & fx_ok & sew_ok & lmul_ok & eew_ok;

  vext_result_reg #(.EEW_W(EEW_W), .EMUL_W(EMUL_W)) u_reg (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .ok_all        (ok_all),
    .sx_en         (sx_en),
    .eew_lg        (eew_lg),
    .emul_lg       (emul_lg),
    .res_valid     (res_valid),
    .res_legal     (res_legal),
    .res_illegal   (res_illegal),
    .res_signed    (res_signed),
    .res_eew_log2  (res_eew_log2),
    .res_emul_log2 (res_emul_log2)
  );

endmodule

// File: rtl/vext_legality_chk.sv
module vext_legality_chk #(
  parameter int EEW_W  = 4,
  parameter int EMUL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        fx_sel,
  input logic              vill,
  input logic              res_valid,
  input logic              res_legal,
  input logic              res_illegal,
  input logic [EEW_W-1:0]  res_eew_log2
);

  p_reset_r1: assert property (@(posedge clk) rst |=> (!res_valid && !res_legal && !res_illegal));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  p_narrow_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_eew_log2 < EEW_W'(3)) |-> res_illegal);

  p_vill_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vill) |=> res_illegal);

  p_rsvd_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fx_sel == 2'b00) |=> res_illegal);

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_legal, res_illegal}) == 1);

  p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_legal && !res_illegal));

endmodule

bind vext_legality vext_legality_chk #(.EEW_W(EEW_W), .EMUL_W(EMUL_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .fx_sel       (fx_sel),
  .vill         (vill),
  .res_valid    (res_valid),
  .res_legal    (res_legal),
  .res_illegal  (res_illegal),
  .res_eew_log2 (res_eew_log2)
);

// File: tb/vext_legality_test.sv
module vext_legality_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  // {fx[1:0], sx, sew[2:0], lmul[2:0], vill, exp_legal, exp_eew[3:0], exp_emul[3:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {2'b01, 1'b0, 3'd0, 3'b000, 1'b0, 1'b0, 4'd2, 4'hF}, // R4 SEW8 x2
    {2'b01, 1'b0, 3'd1, 3'b000, 1'b0, 1'b1, 4'd3, 4'hF}, // R4 SEW16 x2
    {2'b10, 1'b0, 3'd1, 3'b001, 1'b0, 1'b0, 4'd2, 4'hF}, // R4 SEW16 x4
    {2'b11, 1'b1, 3'd1, 3'b000, 1'b0, 1'b0, 4'd1, 4'hD}, // R4 SEW16 x8
    {2'b01, 1'b0, 3'd2, 3'b111, 1'b0, 1'b1, 4'd4, 4'hE}, // R3 SEW32 x2
    {2'b10, 1'b0, 3'd2, 3'b111, 1'b0, 1'b1, 4'd3, 4'hD}, // R5 SEW32 LMUL1/2 x4
    {2'b11, 1'b0, 3'd2, 3'b000, 1'b0, 1'b0, 4'd2, 4'hD}, // R4 SEW32 x8
    {2'b11, 1'b0, 3'd3, 3'b101, 1'b0, 1'b1, 4'd3, 4'hA}, // R5 EMUL 1/64 legal
    {2'b10, 1'b1, 3'd3, 3'b011, 1'b0, 1'b1, 4'd4, 4'h1}, // R3 SEW64 LMUL8 x4
    {2'b01, 1'b0, 3'd3, 3'b011, 1'b1, 1'b0, 4'd5, 4'h2}, // R6 vill
    {2'b00, 1'b0, 3'd3, 3'b000, 1'b0, 1'b0, 4'd6, 4'h0}, // R7 reserved factor
    {2'b01, 1'b0, 3'd4, 3'b000, 1'b0, 1'b0, 4'd6, 4'hF}, // R8 SEW128 unsupported
    {2'b01, 1'b0, 3'd2, 3'b100, 1'b0, 1'b0, 4'd4, 4'hB}, // R8 reserved LMUL
    {2'b10, 1'b0, 3'd2, 3'b101, 1'b0, 1'b1, 4'd3, 4'hB}, // R5 EMUL 1/32 legal
    {2'b01, 1'b1, 3'd1, 3'b101, 1'b0, 1'b1, 4'd3, 4'hC}, // R5 EMUL 1/16 legal
    {2'b11, 1'b1, 3'd3, 3'b010, 1'b0, 1'b1, 4'd3, 4'hF}  // R3 SEW64 x8
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] fx_sel = '0;
  logic       sx_en = 1'b0;
  logic [2:0] sew_sel = '0;
  logic [2:0] lmul_sel = '0;
  logic       vill = 1'b0;
  logic       res_valid, res_legal, res_illegal, res_signed;
  logic [3:0] res_eew_log2, res_emul_log2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vext_legality uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fx_sel(fx_sel), .sx_en(sx_en),
    .sew_sel(sew_sel), .lmul_sel(lmul_sel), .vill(vill),
    .res_valid(res_valid), .res_legal(res_legal), .res_illegal(res_illegal),
    .res_signed(res_signed), .res_eew_log2(res_eew_log2), .res_emul_log2(res_emul_log2)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [18:0] v, input logic val);
    in_valid = val;
    fx_sel   = v[18:17];
    sx_en    = v[16];
    sew_sel  = v[15:13];
    lmul_sel = v[12:10];
    vill     = v[9];
  endtask

  task automatic check_vec(input logic [18:0] v);
    check("R2 valid", 8'(res_valid), 8'd1);
    check("R4/R6/R7/R8 legal", 8'(res_legal), 8'(v[8]));
    check("R9 illegal", 8'(res_illegal), 8'(!v[8]));
    check("R3 eew", 8'(res_eew_log2), 8'(v[7:4]));
    check("R5 emul", 8'(res_emul_log2), 8'(v[3:0]));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", 8'(res_valid), 8'd0);
    check("R1 legal", 8'(res_legal), 8'd0);
    check("R1 illegal", 8'(res_illegal), 8'd0);
    check("R1 eew", 8'(res_eew_log2), 8'd0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i], 1'b1);
      @(negedge clk);
      check_vec(VEC[i]);
      in_valid = 1'b0;
    end

    // R2/R9 idle gap
    @(negedge clk);
    check("R2 idle valid", 8'(res_valid), 8'd0);
    check("R9 idle legal", 8'(res_legal), 8'd0);
    check("R9 idle illegal", 8'(res_illegal), 8'd0);

    // R2 back-to-back strobes
    drive(VEC[1], 1'b1);
    @(negedge clk);
    check_vec(VEC[1]);
    drive(VEC[6], 1'b1);
    @(negedge clk);
    check_vec(VEC[6]);
    in_valid = 1'b0;

    // R10 signedness flip: same verdict, flag follows
    @(negedge clk);
    drive({VEC[7][18:17], 1'b0, VEC[7][15:0]}, 1'b1);
    @(negedge clk);
    check("R10 signed0", 8'(res_signed), 8'd0);
    check("R10 legal s0", 8'(res_legal), 8'd1);
    drive({VEC[7][18:17], 1'b1, VEC[7][15:0]}, 1'b1);
    @(negedge clk);
    check("R10 signed1", 8'(res_signed), 8'd1);
    check("R10 legal s1", 8'(res_legal), 8'd1);
    check("R10 emul s1", 8'(res_emul_log2), 8'hA);
    in_valid = 1'b0;

    // R1 reset with instruction in flight
    @(negedge clk);
    drive(VEC[1], 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R1 flight valid", 8'(res_valid), 8'd0);
    check("R1 flight legal", 8'(res_legal), 8'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule